// File: doc/BRIEF.md
# I2C Slave Receiver with Four-Way Address Match

This block is the receive half of an I2C target. It watches SCL and SDA, assembles each byte that follows a START, and compares the top seven bits of the first byte against four programmable own addresses at once. When one of them matches, the direction bit asks for a write, and the acknowledge enable (AA) is set, it pulls SDA low for the acknowledge bit. It then enters the addressed state, in which it collects data bytes into a receive register.

Every significant bus event raises an interrupt flag (SI) and loads an event code onto the status output. While SI is set after an address or data event, the block holds SCL low. The bus master is therefore stalled until software reads the byte and clears SI through a one-cycle pulse. Clearing AA before a byte ends makes the block refuse that byte and then stop responding until the next START. The byte it refused stays readable. The address comparators are disabled while the surrounding controller reports that it is acting as bus master.

Top module: `i2c_slave_rx`

## Requirements
- R1: After a START, an address byte whose bits [7:1] equal any one of the four own addresses, with bit 0 = 0 (write), received while aa_i=1, is acknowledged by sda_oe_o=1 during the ninth SCL pulse. After that pulse si_o=1 and status_o=0x60. sda_oe_o only changes while SCL is low.
- R2: A matching write address received while aa_i=0 is not acknowledged and leaves si_o at 0.
- R3: An address byte that matches no own address, or that has bit 0 = 1 (read), is not acknowledged. The data bytes that follow it up to the next START are also not acknowledged and do not set si_o.
- R4: While master_active_i=1, the own addresses are not compared. No address byte is acknowledged and si_o stays 0.
- R5: In the addressed state, a data byte received with aa_i=1 is acknowledged. rx_data_o then holds that byte, si_o=1 and status_o=0x80.
- R6: In the addressed state, a data byte received with aa_i=0 is answered with NAK (sda_oe_o=0), rx_data_o holds that byte, si_o=1 and status_o=0x88. Later bytes up to the next START get no acknowledge, do not change rx_data_o and do not set si_o. A STOP after this NAK does not set si_o.
- R7: While si_o=1 with status 0x60, 0x80 or 0x88, scl_oe_o=1 holds SCL low. si_o stays 1 until a si_clr_i pulse, after which scl_oe_o returns to 0.
- R8: A STOP or a repeated START in the addressed state sets si_o=1 with status_o=0xA0, without holding SCL. After a repeated START, a matching write address is acknowledged again with status 0x60.
- R9: While si_o=0, status_o reads 0xF8. After reset si_o, sda_oe_o and scl_oe_o are 0 and rx_data_o is 0x00.
- R10: Bits are taken most significant first, one bit per rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 28 | Four 7-bit own addresses; entry k is bits [7k+6:7k] |
| master_active_i | input | 1 | 1 while the controller acts as bus master; disables matching |
| aa_i | input | 1 | Acknowledge enable |
| si_clr_i | input | 1 | One-cycle pulse that clears si_o |
| si_o | output | 1 | Event flag |
| status_o | output | 8 | Event code while si_o=1, 0xF8 otherwise |
| rx_data_o | output | 8 | Last data byte taken in the addressed state |

## Verification
The bench targets these corner cases:
- A byte with bit 0 set, sent to an own address. A design that ignored the direction bit would acknowledge it.
- A match against each of the four address slots. A comparator wired to the wrong slice would miss one of them.
- The byte refused after AA drops. A design that failed to leave the addressed state would keep acknowledging later bytes or overwrite rx_data_o.
- A STOP after that refusal. A design that still counted itself addressed would raise 0xA0.
- An asymmetric data pattern. This exposes a reversed bit order.
- A repeated START in the middle of a transfer. A design that missed it would neither report 0xA0 nor accept the next address.

The random transactions are checked against a model of the ACK and NAK rules, and mix address hits, misses, reads and master-mode blocking.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } srx_state_e;

    typedef enum logic [7:0] {
        STS_ADDR_W_ACK = 8'h60,
        STS_DATA_ACK   = 8'h80,
        STS_DATA_NAK   = 8'h88,
        STS_STOP_RS    = 8'hA0,
        STS_NONE       = 8'hF8
    } srx_status_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic rw_is_write(input logic rw_bit);
        return ~rw_bit;
    endfunction

    function automatic srx_status_e data_code(input logic acked);
        return acked ? STS_DATA_ACK : STS_DATA_NAK;
    endfunction

endpackage

// File: rtl/i2c_srx_bus_sampler.sv
module i2c_srx_bus_sampler
    import i2c_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_now;
    logic                   sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[TOP-1:0], scl_i};
            sda_sr <= {sda_sr[TOP-1:0], sda_i};
            scl_q  <= scl_sr[TOP];
            sda_q  <= sda_sr[TOP];
        end
    end

    assign scl_now = scl_sr[TOP];
    assign sda_now = sda_sr[TOP];

    always_comb begin
        evt.scl_rise = scl_now & ~scl_q;
        evt.scl_fall = ~scl_now & scl_q;
        evt.start    = scl_now & scl_q & sda_q & ~sda_now;
        evt.stop     = scl_now & scl_q & ~sda_q & sda_now;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2c_srx_addr_match.sv
module i2c_srx_addr_match
    import i2c_srx_pkg::*;
#(
    parameter int NUM_ADDR = 4
) (
    input  logic [ADDR_W-1:0]          addr_field,
    input  logic [NUM_ADDR*ADDR_W-1:0] own_addr,
    input  logic                       master_active,
    output logic                       hit
);

    logic [NUM_ADDR-1:0] slot_hit;

    for (genvar k = 0; k < NUM_ADDR; k++) begin : g_slot
        assign slot_hit[k] = (addr_field == own_addr[k*ADDR_W +: ADDR_W]);
    end

    assign hit = (|slot_hit) & ~master_active;

endmodule

// File: rtl/i2c_srx_shifter.sv
module i2c_srx_shifter
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] data,
    output logic              full
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            data  <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (shift_en && !full) begin
            data  <= {data[BYTE_W-2:0], bit_in};
            count <= count + 1'b1;
        end
    end

    assign full = (count == CNT_W'(BYTE_W));

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_srx_pkg::*;
#(
    parameter int NUM_ADDR    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       scl_oe_o,
    output logic                       sda_oe_o,
    input  logic [NUM_ADDR*ADDR_W-1:0] own_addr_i,
    input  logic                       master_active_i,
    input  logic                       aa_i,
    input  logic                       si_clr_i,
    output logic                       si_o,
    output logic [7:0]                 status_o,
    output logic [BYTE_W-1:0]          rx_data_o
);

    bus_evt_t          evt;
    srx_state_e        state;
    srx_status_e       code;
    logic              si;
    logic              sda_oe;
    logic              ack_q;
    logic [BYTE_W-1:0] rx_data;
    logic [BYTE_W-1:0] shift_byte;
    logic              shift_full;
    logic              shift_clr;
    logic              shift_en;
    logic              addr_hit;
    logic              addressed;
    logic              ack_end;

    i2c_srx_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_srx_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .clr      (shift_clr),
        .shift_en (shift_en),
        .bit_in   (evt.sda),
        .data     (shift_byte),
        .full     (shift_full)
    );

    i2c_srx_addr_match #(.NUM_ADDR(NUM_ADDR)) u_match (
        .addr_field    (shift_byte[BYTE_W-1:1]),
        .own_addr      (own_addr_i),
        .master_active (master_active_i),
        .hit           (addr_hit)
    );

    assign addressed = (state == ST_DATA) || (state == ST_DATA_ACK);
    assign ack_end   = evt.scl_fall && ((state == ST_ADDR_ACK) || (state == ST_DATA_ACK));
    assign shift_clr = evt.start || ack_end;
    assign shift_en  = evt.scl_rise && ((state == ST_ADDR) || (state == ST_DATA));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            code    <= STS_NONE;
            si      <= 1'b0;
            sda_oe  <= 1'b0;
            ack_q   <= 1'b0;
            rx_data <= '0;
        end else begin
            if (si_clr_i) begin
                si <= 1'b0;
            end
            if (evt.start || evt.stop) begin
                if (addressed) begin
                    si   <= 1'b1;
                    code <= STS_STOP_RS;
                end
                sda_oe <= 1'b0;
                state  <= evt.start ? ST_ADDR : ST_IDLE;
            end else if (evt.scl_fall) begin
                case (state)
                    ST_ADDR: begin
                        if (shift_full) begin
                            if (addr_hit && rw_is_write(shift_byte[0]) && aa_i) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        sda_oe <= 1'b0;
                        si     <= 1'b1;
                        code   <= STS_ADDR_W_ACK;
                        state  <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (shift_full) begin
                            rx_data <= shift_byte;
                            sda_oe  <= aa_i;
                            ack_q   <= aa_i;
                            state   <= ST_DATA_ACK;
                        end
                    end
                    ST_DATA_ACK: begin
                        sda_oe <= 1'b0;
                        si     <= 1'b1;
                        code   <= data_code(ack_q);
                        state  <= ack_q ? ST_DATA : ST_IGNORE;
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign si_o      = si;
    assign status_o  = si ? code : STS_NONE;
    assign scl_oe_o  = si && (code != STS_STOP_RS);
    assign sda_oe_o  = sda_oe;
    assign rx_data_o = rx_data;

endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       si_clr_i,
    input logic       si_o,
    input logic [7:0] status_o,
    input logic       scl_oe_o,
    input logic       sda_oe_o
);

    assert_sda_moves_scl_low_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sda_oe_o != $past(sda_oe_o))) |-> !$past(scl_i));

    assert_si_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (si_o && !si_clr_i) |=> si_o);

    assert_stretch_needs_si_R7: assert property (@(posedge clk) disable iff (rst)
        scl_oe_o |-> si_o);

    assert_idle_code_R9: assert property (@(posedge clk) disable iff (rst)
        !si_o |-> (status_o == 8'hF8));

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
        si_o |-> ((status_o == 8'h60) || (status_o == 8'h80) ||
                  (status_o == 8'h88) || (status_o == 8'hA0)));

    assert_stop_no_stretch_R8: assert property (@(posedge clk) disable iff (rst)
        (si_o && (status_o == 8'hA0)) |-> !scl_oe_o);

endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .si_clr_i (si_clr_i),
    .si_o     (si_o),
    .status_o (status_o),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
);

// File: tb/i2c_slave_rx_tb.sv
module i2c_slave_rx_tb;

    localparam int HALF = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic        scl_oe, sda_oe;
    logic        master_active = 1'b0;
    logic        aa = 1'b1;
    logic        si_clr = 1'b0;
    logic        si;
    logic [7:0]  status;
    logic [7:0]  rx_data;
    logic [6:0]  own [4];
    logic [27:0] own_flat;
    logic        scl_line, sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit addressed_m;
    logic [7:0] rx_m;

    always #5 clk = ~clk;

    assign scl_line = scl_drv & ~scl_oe;
    assign sda_line = sda_drv & ~sda_oe;
    assign own_flat = {own[3], own[2], own[1], own[0]};

    i2c_slave_rx u_dut (
        .clk             (clk),
        .rst             (rst),
        .scl_i           (scl_line),
        .sda_i           (sda_line),
        .scl_oe_o        (scl_oe),
        .sda_oe_o        (sda_oe),
        .own_addr_i      (own_flat),
        .master_active_i (master_active),
        .aa_i            (aa),
        .si_clr_i        (si_clr),
        .si_o            (si),
        .status_o        (status),
        .rx_data_o       (rx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        scl_drv = 1'b1;
        @(negedge clk);
        while (scl_oe) @(negedge clk);
        wait_cyc(HALF);
    endtask

    task automatic scl_low();
        scl_drv = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic bus_start();
        if (!scl_drv) begin
            sda_drv = 1'b1;
            wait_cyc(HALF);
            scl_high();
        end
        sda_drv = 1'b0;
        wait_cyc(HALF);
        scl_low();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0;
        wait_cyc(HALF);
        scl_high();
        sda_drv = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i];
            wait_cyc(HALF);
            scl_high();
            scl_low();
        end
        sda_drv = 1'b1;
        wait_cyc(HALF);
        scl_high();
        acked = ~sda_line;
        scl_low();
    endtask

    task automatic clear_si();
        si_clr = 1'b1;
        @(negedge clk);
        si_clr = 1'b0;
        wait_cyc(2);
    endtask

    function automatic bit addr_hits(input logic [6:0] a);
        return (a == own[0]) || (a == own[1]) || (a == own[2]) || (a == own[3]);
    endfunction

    function automatic bit exp_addr_ack(input logic [6:0] a, input bit rw, input bit aa_v, input bit mst);
        return addr_hits(a) && !rw && aa_v && !mst;
    endfunction

    // address phase, checked against the model
    task automatic do_addr(input logic [6:0] a, input bit rw, input string req);
        logic ack;
        bit   exp;
        exp = exp_addr_ack(a, rw, aa, master_active);
        send_byte({a, rw}, ack);
        wait_cyc(4);
        check({req, " addr ack"}, ack, exp);
        check({req, " addr si"}, si, exp);
        if (exp) begin
            check({req, " status 0x60"}, status, 8'h60);
            check({req, " R7 stretch"}, scl_oe, 1'b1);
            clear_si();
            check({req, " R7 released"}, scl_oe, 1'b0);
            check({req, " R9 idle code"}, status, 8'hF8);
        end
        addressed_m = exp;
    endtask

    // data phase, checked against the model
    task automatic do_data(input logic [7:0] d, input string req);
        logic ack;
        bit   was;
        was = addressed_m;
        send_byte(d, ack);
        wait_cyc(4);
        if (was) begin
            rx_m = d;
            check({req, " data ack"}, ack, aa);
            check({req, " data si"}, si, 1'b1);
            check({req, " data code"}, status, aa ? 8'h80 : 8'h88);
            check({req, " R7 stretch"}, scl_oe, 1'b1);
            addressed_m = aa;
            clear_si();
        end else begin
            check({req, " ignored ack"}, ack, 1'b0);
            check({req, " ignored si"}, si, 1'b0);
        end
        check({req, " rx_data"}, rx_data, rx_m);
    endtask

    task automatic do_stop(input string req);
        bus_stop();
        wait_cyc(4);
        check({req, " stop si"}, si, addressed_m);
        if (addressed_m) begin
            check({req, " R8 stop code"}, status, 8'hA0);
            check({req, " R8 no stretch"}, scl_oe, 1'b0);
            clear_si();
        end
        addressed_m = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        own[0] = 7'h12;
        own[1] = 7'h35;
        own[2] = 7'h4C;
        own[3] = 7'h71;
        rx_m = 8'h00;
        addressed_m = 1'b0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);

        // R9 reset state
        check("R9 reset si", si, 1'b0);
        check("R9 reset sda_oe", sda_oe, 1'b0);
        check("R9 reset scl_oe", scl_oe, 1'b0);
        check("R9 reset status", status, 8'hF8);
        check("R9 reset rx_data", rx_data, 8'h00);

        // R1 slot 2 hit; R5/R10 asymmetric byte; R6 NAK path
        bus_start();
        aa = 1'b1;
        do_addr(own[2], 1'b0, "R1");
        do_data(8'h1B, "R5 R10");
        check("R10 msb first", rx_data, 8'h1B);
        aa = 1'b0;
        do_data(8'h6E, "R6 nak");
        aa = 1'b1;
        do_data(8'hFF, "R6 after nak");
        check("R6 kept byte", rx_data, 8'h6E);
        do_stop("R6 stop after nak");

        // R3 read to own address, then data ignored
        bus_start();
        do_addr(own[0], 1'b1, "R3 read");
        do_data(8'h55, "R3 ignored data");
        do_stop("R3");

        // R3 miss
        bus_start();
        do_addr(7'h00, 1'b0, "R3 miss");
        do_stop("R3 miss");

        // R2 aa low at address
        bus_start();
        aa = 1'b0;
        do_addr(own[1], 1'b0, "R2");
        aa = 1'b1;
        do_stop("R2");

        // R4 master active
        bus_start();
        master_active = 1'b1;
        do_addr(own[3], 1'b0, "R4");
        master_active = 1'b0;
        do_stop("R4");

        // R8 stop while addressed, slot 3
        bus_start();
        do_addr(own[3], 1'b0, "R1 slot3");
        do_data(8'hC3, "R5");
        do_stop("R8");

        // R8 repeated start, then slot 0 and slot 1
        bus_start();
        do_addr(own[0], 1'b0, "R1 slot0");
        bus_start();
        wait_cyc(4);
        check("R8 rs si", si, 1'b1);
        check("R8 rs code", status, 8'hA0);
        clear_si();
        do_addr(own[1], 1'b0, "R8 readdress");
        do_data(8'h96, "R5");
        do_stop("R8");

        // constrained random transactions
        for (int it = 0; it < 30; it++) begin
            int         sel;
            int         nb;
            logic [6:0] a;
            bit         rw;
            sel = int'($urandom % 5);
            a   = (sel < 4) ? own[sel] : 7'($urandom);
            rw  = ($urandom % 4) == 0;
            aa  = ($urandom % 5) != 0;
            master_active = ($urandom % 8) == 0;
            bus_start();
            do_addr(a, rw, "R1 R2 R3 R4 rand");
            master_active = 1'b0;
            nb = 1 + int'($urandom % 3);
            for (int j = 0; j < nb; j++) begin
                aa = ($urandom % 4) != 0;
                do_data(8'($urandom), "R5 R6 rand");
            end
            do_stop("R8 rand");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule